// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for a single DMA channel. Software sets a start address, an inner (row) element count and signed stride, an outer (row count) value and signed stride, an element size and a few mode bits, then pulses `start`. From the next cycle on, the block offers one byte address at a time on a valid/ready interface and moves to the following address on each accepted handshake. Every offered address carries a row-end flag and a buffer-end flag.

Inside a row, each address is the previous address plus the inner stride. At the end of a row, the outer stride is added in its place. The outer stride may be smaller than the inner stride, or of opposite sign. This lets interleaved streams be separated in a single pass. A one-dimensional mode uses only the inner count and stride.

When the buffer ends, the channel either goes idle (stop mode) or reloads the start address and both counters and keeps running (circular mode). A one-cycle interrupt pulse marks buffer completion. In circular mode the pulse can instead be raised at the end of every row.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `addr_valid`, `row_last`, `buf_last` and `irq` are all 0.
- R2: A `start` pulse while idle latches the configuration. From the next cycle, `busy` and `addr_valid` are 1 and `addr` equals the start address. `addr_valid` stays 1 for as long as the channel is busy.
- R3: Within a row, the next address is the current address plus the inner stride (a two's complement signed value) times the element size. `addr` holds while `addr_valid` is 1 and `addr_ready` is 0.
- R4: In two-dimensional mode (`cfg_two_d`=1), the handshake on the last element of a row that is not the final row adds the outer stride times the element size in place of the inner stride. The outer stride may be negative or smaller than the inner stride.
- R5: Strides are scaled by the element size code `cfg_elem_size`: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R6: A count value of 0 means 65536 elements.
- R7: In one-dimensional mode (`cfg_two_d`=0), the outer count and outer stride have no effect. `row_last` equals `buf_last` and marks the last of the inner-count elements.
- R8: In stop mode (`cfg_circular`=0), `busy` and `addr_valid` drop in the cycle after the handshake of the final element. `irq` is 1 for exactly that one cycle.
- R9: In circular mode (`cfg_circular`=1), the handshake of the final element reloads the start address and both counters, and the channel stays busy.
- R10: In circular mode with `cfg_row_irq`=1, `irq` pulses in the cycle after every row-end handshake. With `cfg_row_irq`=0, it pulses only after the buffer-end handshake. `irq` is 0 in every other cycle.
- R11: A `start` pulse, or any configuration change, while busy has no effect on the address sequence.
- R12: `row_last` is 1 on the last element of each row. `buf_last` is 1 only on the final element of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts the channel when idle |
| cfg_start_addr | input | ADDR_W | First byte address |
| cfg_inner_count | input | CNT_W | Elements per row (0 = 65536) |
| cfg_inner_stride | input | STRIDE_W | Signed step within a row, in elements |
| cfg_outer_count | input | CNT_W | Rows per buffer (0 = 65536) |
| cfg_outer_stride | input | STRIDE_W | Signed step applied at a row end, in elements |
| cfg_two_d | input | 1 | 1 = two-dimensional, 0 = one-dimensional |
| cfg_circular | input | 1 | 1 = circular reload, 0 = stop at end |
| cfg_row_irq | input | 1 | Circular mode: interrupt on every row |
| cfg_elem_size | input | 2 | Element size code (0:1B, 1:2B, 2/3:4B) |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | An address is offered |
| addr | output | ADDR_W | Current byte address |
| row_last | output | 1 | Current element ends a row |
| buf_last | output | 1 | Current element ends the buffer |
| busy | output | 1 | Channel active |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench goes after these corner cases:

- **Row-end step.** A design that applied the inner stride at the row end, or lost the sign of a negative outer stride, would walk off the interleaved pattern at the first row boundary.
- **Count of zero.** A count of 0 must run 65536 elements. A design that treated it as empty, or as a count of 1, would end the buffer at once.
- **Final element in both end modes.** A wrong circular reload would continue from the last address instead of the start. A slip in the stop path would leave `addr_valid` high, or give a missing or doubled `irq`.
- **Start and configuration changes while busy.** A design that accepted them would jump to a new address in mid-buffer.

// File: rtl/dma2d_pkg.sv
// Shared types and helpers for the 2D DMA address generator.
// Assumes element sizes are powers of two up to 4 bytes.
package dma2d_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_WIDE = 2'd3
    } elem_size_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } chan_state_e;

    // Map an element size code to a left-shift amount (code 3 acts as 4 bytes).
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        case (elem_size_e'(code))
            ESZ_BYTE: return 2'd0;
            ESZ_HALF: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dma2d_dim_counter.sv
// One dimension counter: counts element positions 0..len-1 and wraps.
// len is taken modulo 2^CNT_W, so a length of 0 gives a full 2^CNT_W span.
// Assumes len is stable while step can be asserted.
module dma2d_dim_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] len,
    output logic             is_last
);
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] last_idx;

    // Last valid index; wraps so that len = 0 selects the largest index.
    assign last_idx = len - 1'b1;
    assign is_last  = (idx == last_idx);

    // Position register: cleared on load, advanced or wrapped on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= is_last ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/dma2d_addr_step.sv
// Combinational next-address computation: picks the inner or outer
// stride, sign-extends it to the address width, scales it by the element
// size and adds it to the current address. Address arithmetic wraps.
module dma2d_addr_step
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic [ADDR_W-1:0]   cur_addr,
    input  logic [STRIDE_W-1:0] inner_stride,
    input  logic [STRIDE_W-1:0] outer_stride,
    input  logic                use_outer,
    input  logic [1:0]          elem_size,
    output logic [ADDR_W-1:0]   next_addr
);
    logic [STRIDE_W-1:0] sel_stride;
    logic [ADDR_W-1:0]   wide_stride;
    logic [ADDR_W-1:0]   byte_step;

    // Select the stride for this step.
    assign sel_stride = use_outer ? outer_stride : inner_stride;

    // Fit the signed stride to the address width.
    generate
        if (ADDR_W > STRIDE_W) begin : g_sext
            assign wide_stride = {{(ADDR_W-STRIDE_W){sel_stride[STRIDE_W-1]}}, sel_stride};
        end else begin : g_trunc
            assign wide_stride = sel_stride[ADDR_W-1:0];
        end
    endgenerate

    // Scale by the element size and add.
    assign byte_step = wide_stride << size_shift(elem_size);
    assign next_addr = cur_addr + byte_step;
endmodule

// File: rtl/dma2d_ctrl.sv
// Channel control: an idle/run state machine and the configuration
// snapshot taken when a start is accepted. Starts while running are
// dropped. Assumes the buffer-end flag is valid whenever hs is high.
module dma2d_ctrl
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_start_addr,
    input  logic [CNT_W-1:0]    cfg_inner_count,
    input  logic [STRIDE_W-1:0] cfg_inner_stride,
    input  logic [CNT_W-1:0]    cfg_outer_count,
    input  logic [STRIDE_W-1:0] cfg_outer_stride,
    input  logic                cfg_two_d,
    input  logic                cfg_circular,
    input  logic                cfg_row_irq,
    input  logic [1:0]          cfg_elem_size,
    input  logic                hs,
    input  logic                buf_end,
    output logic                running,
    output logic                load,
    output logic [ADDR_W-1:0]   lat_start_addr,
    output logic [CNT_W-1:0]    lat_inner_count,
    output logic [STRIDE_W-1:0] lat_inner_stride,
    output logic [CNT_W-1:0]    lat_outer_count,
    output logic [STRIDE_W-1:0] lat_outer_stride,
    output logic                lat_two_d,
    output logic                lat_circular,
    output logic                lat_row_irq,
    output logic [1:0]          lat_elem_size
);
    chan_state_e state;

    assign running = (state == CH_RUN);
    assign load    = start && (state == CH_IDLE);

    // State machine: enter run on an accepted start, leave at the stop-mode end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else if (load) begin
            state <= CH_RUN;
        end else if (hs && buf_end && !lat_circular) begin
            state <= CH_IDLE;
        end
    end

    // Configuration snapshot, taken only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_start_addr   <= '0;
            lat_inner_count  <= '0;
            lat_inner_stride <= '0;
            lat_outer_count  <= '0;
            lat_outer_stride <= '0;
            lat_two_d        <= 1'b0;
            lat_circular     <= 1'b0;
            lat_row_irq      <= 1'b0;
            lat_elem_size    <= '0;
        end else if (load) begin
            lat_start_addr   <= cfg_start_addr;
            lat_inner_count  <= cfg_inner_count;
            lat_inner_stride <= cfg_inner_stride;
            lat_outer_count  <= cfg_outer_count;
            lat_outer_stride <= cfg_outer_stride;
            lat_two_d        <= cfg_two_d;
            lat_circular     <= cfg_circular;
            lat_row_irq      <= cfg_row_irq;
            lat_elem_size    <= cfg_elem_size;
        end
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
// 2D DMA address generator top. Offers one byte address per valid/ready
// handshake, walks rows with the inner stride and row ends with the outer
// stride, and stops or reloads at the buffer end. Synchronous active-low
// reset. Assumes ADDR_W is at least STRIDE_W + 2 for full stride range.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_start_addr,
    input  logic [CNT_W-1:0]    cfg_inner_count,
    input  logic [STRIDE_W-1:0] cfg_inner_stride,
    input  logic [CNT_W-1:0]    cfg_outer_count,
    input  logic [STRIDE_W-1:0] cfg_outer_stride,
    input  logic                cfg_two_d,
    input  logic                cfg_circular,
    input  logic                cfg_row_irq,
    input  logic [1:0]          cfg_elem_size,
    input  logic                addr_ready,
    output logic                addr_valid,
    output logic [ADDR_W-1:0]   addr,
    output logic                row_last,
    output logic                buf_last,
    output logic                busy,
    output logic                irq
);
    logic                running, load, hs;
    logic                x_last, y_last, row_end, buf_end;
    logic [ADDR_W-1:0]   lat_start_addr, next_addr, addr_q;
    logic [CNT_W-1:0]    lat_inner_count, lat_outer_count;
    logic [STRIDE_W-1:0] lat_inner_stride, lat_outer_stride;
    logic                lat_two_d, lat_circular, lat_row_irq;
    logic [1:0]          lat_elem_size;
    logic                irq_q;

    dma2d_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .cfg_start_addr   (cfg_start_addr),
        .cfg_inner_count  (cfg_inner_count),
        .cfg_inner_stride (cfg_inner_stride),
        .cfg_outer_count  (cfg_outer_count),
        .cfg_outer_stride (cfg_outer_stride),
        .cfg_two_d        (cfg_two_d),
        .cfg_circular     (cfg_circular),
        .cfg_row_irq      (cfg_row_irq),
        .cfg_elem_size    (cfg_elem_size),
        .hs               (hs),
        .buf_end          (buf_end),
        .running          (running),
        .load             (load),
        .lat_start_addr   (lat_start_addr),
        .lat_inner_count  (lat_inner_count),
        .lat_inner_stride (lat_inner_stride),
        .lat_outer_count  (lat_outer_count),
        .lat_outer_stride (lat_outer_stride),
        .lat_two_d        (lat_two_d),
        .lat_circular     (lat_circular),
        .lat_row_irq      (lat_row_irq),
        .lat_elem_size    (lat_elem_size)
    );

    // Handshake and end-of-row / end-of-buffer decode.
    assign hs      = running && addr_ready;
    assign row_end = x_last;
    assign buf_end = x_last && (!lat_two_d || y_last);

    // Inner (element) counter.
    dma2d_dim_counter #(.CNT_W(CNT_W)) u_x_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .step    (hs),
        .len     (lat_inner_count),
        .is_last (x_last)
    );

    // Outer (row) counter, stepped only at row ends in 2D mode.
    dma2d_dim_counter #(.CNT_W(CNT_W)) u_y_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .step    (hs && x_last && lat_two_d),
        .len     (lat_outer_count),
        .is_last (y_last)
    );

    dma2d_addr_step #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_step (
        .cur_addr     (addr_q),
        .inner_stride (lat_inner_stride),
        .outer_stride (lat_outer_stride),
        .use_outer    (row_end && lat_two_d),
        .elem_size    (lat_elem_size),
        .next_addr    (next_addr)
    );

    // Address register: load on start, reload at buffer end, step otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= cfg_start_addr;
        end else if (hs) begin
            addr_q <= buf_end ? lat_start_addr : next_addr;
        end
    end

    // Interrupt pulse: buffer end always, row end when circular row mode is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= hs && (buf_end || (lat_circular && lat_row_irq && row_end));
        end
    end

    assign addr_valid = running;
    assign busy       = running;
    assign addr       = addr_q;
    assign row_last   = running && row_end;
    assign buf_last   = running && buf_end;
    assign irq        = irq_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
// Property checker for dma2d_addr_gen, attached by bind. Observes ports only.
module dma2d_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              addr_ready,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              row_last,
    input logic              buf_last,
    input logic              busy,
    input logic              irq
);
    // Idle channel shows no address or flags.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!addr_valid && !row_last && !buf_last));

    // Activity only begins after a start request.
    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // Address holds while stalled.
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> $stable(addr));

    // Stop-mode end: only after a final handshake, with an interrupt.
    assert_stop_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(buf_last && addr_ready) && irq));

    // Interrupts follow handshakes only.
    assert_irq_after_hs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(addr_valid && addr_ready));

    // Start while busy changes nothing during a stall.
    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !addr_ready) |=> ($stable(addr) && busy));

    // Buffer end is always also a row end.
    assert_flag_nest_R12: assert property (@(posedge clk) disable iff (!rst_n)
        buf_last |-> row_last);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .addr_ready (addr_ready),
    .addr_valid (addr_valid),
    .addr       (addr),
    .row_last   (row_last),
    .buf_last   (buf_last),
    .busy       (busy),
    .irq        (irq)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_start_addr = '0;
    logic [15:0] cfg_inner_count = '0;
    logic [15:0] cfg_inner_stride = '0;
    logic [15:0] cfg_outer_count = '0;
    logic [15:0] cfg_outer_stride = '0;
    logic        cfg_two_d = 1'b0;
    logic        cfg_circular = 1'b0;
    logic        cfg_row_irq = 1'b0;
    logic [1:0]  cfg_elem_size = '0;
    logic        addr_ready = 1'b0;
    logic        addr_valid, row_last, buf_last, busy, irq;
    logic [31:0] addr;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma2d_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_start_addr(cfg_start_addr), .cfg_inner_count(cfg_inner_count),
        .cfg_inner_stride(cfg_inner_stride), .cfg_outer_count(cfg_outer_count),
        .cfg_outer_stride(cfg_outer_stride), .cfg_two_d(cfg_two_d),
        .cfg_circular(cfg_circular), .cfg_row_irq(cfg_row_irq),
        .cfg_elem_size(cfg_elem_size), .addr_ready(addr_ready),
        .addr_valid(addr_valid), .addr(addr), .row_last(row_last),
        .buf_last(buf_last), .busy(busy), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; addr_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(addr_valid == 1'b0, "R1 valid", addr_valid, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    // Run one configuration and compare every offered address to the model.
    task automatic run_seq(input logic [31:0] sa, input logic [15:0] xc, input logic [15:0] xs,
                           input logic [15:0] yc, input logic [15:0] ys, input bit td,
                           input bit circ, input bit rirq, input logic [1:0] esz,
                           input int max_hs, input int pct, input bit inject, input string tag);
        int xlen = (xc == 0) ? 65536 : int'(xc);
        int ylen = (yc == 0) ? 65536 : int'(yc);
        int sh   = (esz == 2'd0) ? 0 : (esz == 2'd1) ? 1 : 2;
        int hs = 0, xi = 0, yi = 0;
        bit irq_exp = 1'b0, fin = 1'b0, rl, bl, rdy;
        logic [31:0] ea = sa;
        cfg_start_addr = sa; cfg_inner_count = xc; cfg_inner_stride = xs;
        cfg_outer_count = yc; cfg_outer_stride = ys; cfg_two_d = td;
        cfg_circular = circ; cfg_row_irq = rirq; cfg_elem_size = esz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(addr == sa, "R2 first address", addr, sa);
        while (hs < max_hs && !fin) begin
            rl = (xi == xlen - 1);
            bl = rl && (!td || yi == ylen - 1);
            chk(irq == irq_exp, circ ? "R10 irq" : "R8 irq", irq, irq_exp);
            chk(addr_valid == 1'b1, circ ? "R9 valid" : "R2 valid", addr_valid, 1);
            chk(addr == ea, tag, addr, ea);
            chk(row_last == rl, "R12 row_last", row_last, rl);
            chk(buf_last == bl, td ? "R12 buf_last" : "R7 buf_last", buf_last, bl);
            if (inject && (hs % 5 == 2)) begin
                // R11: new start and config while busy must be ignored
                start = 1'b1;
                cfg_start_addr = ~sa; cfg_inner_count = 16'd1; cfg_inner_stride = 16'h0100;
                cfg_outer_stride = 16'h0200; cfg_two_d = ~td; cfg_circular = ~circ;
            end
            rdy = ($urandom % 100) < pct;
            addr_ready = rdy;
            irq_exp = 1'b0;
            if (rdy) begin
                hs++;
                irq_exp = bl || (circ && rirq && rl);
                if (bl) begin
                    ea = sa; xi = 0; yi = 0;
                    if (!circ) fin = 1'b1;
                end else if (rl) begin
                    ea = ea + (sext(ys) << sh); xi = 0; yi++;
                end else begin
                    ea = ea + (sext(xs) << sh); xi++;
                end
            end
            @(negedge clk);
            start = 1'b0;
        end
        addr_ready = 1'b0;
        if (fin) begin
            chk(busy == 1'b0, "R8 busy drops", busy, 0);
            chk(addr_valid == 1'b0, "R8 valid drops", addr_valid, 0);
            chk(irq == 1'b1, "R8 done irq", irq, 1);
            @(negedge clk);
            chk(irq == 1'b0, "R8 irq one cycle", irq, 0);
            chk(busy == 1'b0, "R8 stays idle", busy, 0);
        end else begin
            do_reset();
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R4: de-interleave, outer stride negative and smaller than inner
        run_seq(32'h0000_1000, 16'd4, 16'd3, 16'd3, 16'hFFF8, 1'b1, 1'b0, 1'b0, 2'd0, 1000, 70, 1'b0, "R4 deinterleave addr");
        // R5: 2-byte and 4-byte elements, code 3 as 4 bytes
        run_seq(32'h0000_8000, 16'd3, 16'd2, 16'd2, 16'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1000, 60, 1'b0, "R5 half addr");
        run_seq(32'h0001_0000, 16'd3, 16'hFFFF, 16'd3, 16'd7, 1'b1, 1'b0, 1'b0, 2'd3, 1000, 80, 1'b0, "R5 word addr");
        // R7: 1D ignores outer values
        run_seq(32'h0002_0000, 16'd5, 16'd4, 16'd9, 16'h8000, 1'b0, 1'b0, 1'b0, 2'd2, 1000, 50, 1'b0, "R7 1d addr");
        // R9/R10: circular with row interrupts, then with buffer interrupts
        run_seq(32'h0003_0000, 16'd3, 16'd1, 16'd2, 16'd5, 1'b1, 1'b1, 1'b1, 2'd0, 16, 70, 1'b0, "R9 circ row addr");
        run_seq(32'h0004_0000, 16'd2, 16'd8, 16'd3, 16'hFFF0, 1'b1, 1'b1, 1'b0, 2'd2, 20, 70, 1'b0, "R9 circ buf addr");
        run_seq(32'h0004_8000, 16'd1, 16'd1, 16'd3, 16'd2, 1'b1, 1'b1, 1'b1, 2'd0, 8, 100, 1'b0, "R10 one-element rows");
        // R11: start and config changes while busy
        run_seq(32'h0005_0000, 16'd4, 16'd1, 16'd3, 16'd16, 1'b1, 1'b0, 1'b0, 2'd0, 1000, 60, 1'b1, "R11 addr");
        // R3: random configurations with random stalls
        for (int k = 0; k < 15; k++) begin
            run_seq($urandom, 16'($urandom_range(1, 6)), 16'($urandom), 16'($urandom_range(1, 5)),
                    16'($urandom), 1'($urandom), 1'b0, 1'b0, 2'($urandom), 1000, 65, 1'b0, "R3 random addr");
        end
        // R6: inner count 0 runs 65536 elements
        run_seq(32'h2000_0000, 16'd0, 16'd1, 16'd1, 16'd0, 1'b0, 1'b0, 1'b0, 2'd0, 70000, 100, 1'b0, "R6 count zero addr");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule